// File: doc/BRIEF.md
# Serial-Bus Slave with One Indexed Control Register

This block is a two-wire serial-bus slave that owns a single 8-bit control register. Each bit of the register drives the enable of one switch in a bank of eight parallel load resistors. Setting every bit enables every path, which gives the lowest resistance. Setting a single bit, in any position, enables exactly one path. The slave's 7-bit address is built from four active-low strap pins, with three fixed low-order bits after them. SCL and SDA are sampled by a faster system clock. SDA is returned only as an open-drain pull-down enable.

Every transaction sends a device-address byte and then an index byte. The index byte carries a 7-bit register index and its own read/write bit. A write puts a data byte after the index, and the slave loads it into the register. A read needs two transactions. The first is a write-direction transaction whose index byte ends in 1, which arms readback. The second is a read-direction transaction, in which the slave shifts the register out. Clock stretching, multi-byte bursts and general call are not supported.

Top module: `i2c_idxreg_slave`

## Requirements
- R1: The slave address is {~strap_n[3:0], 3'b011}, so with all straps high it is 7'b0000011. The first byte after START is that address followed by a direction bit, where 0 means write and 1 means read. A matching address byte is acknowledged by pulling SDA low during the 9th clock.
- R2: A device-address byte that does not match gets no acknowledge. The slave then ignores every later byte, and ctrl_q stays unchanged, until the next START.
- R3: The only index that is accepted is 7'b0000011, sent as the upper 7 bits of the second byte. Any other index gets no acknowledge, and a data byte that follows it is not acknowledged and is not written.
- R4: A write sequence is address+0, index+0, then a data byte. The slave acknowledges the data byte and loads it into ctrl_q. ctrl_q changes only on such a load, and the load clears the read-pending flag.
- R5: A write-direction transaction whose index byte ends in 1 sets the read-pending flag. In a later read-direction transaction (address+1, index+1), the slave shifts ctrl_q out MSB first, with one bit per SCL clock.
- R6: A read-direction transaction while the read-pending flag is clear returns 0xFF, because SDA is released for all eight bits.
- R7: sda_oe changes only after a falling SCL edge has been detected, or when it is released on START or STOP. It therefore never changes while SCL is high within a byte.
- R8: A START at any point, including in the middle of a byte, restarts address reception. A STOP releases SDA and returns the slave to idle.
- R9: While rst_n is low, ctrl_q is 8'h00, sda_oe is 0 and the read-pending flag is clear.
- R10: In a write-direction transaction with index+1, a data byte that follows gets no acknowledge and ctrl_q stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_n | input | 4 | Active-low address straps, upper four address bits |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| ctrl_q | output | 8 | Resistor-path enables, one bit per path |

## Verification
Fixed transactions first cover the corners. These are a read before any arming, a single-bit pattern, and an armed read after an index+1 write. They also cover a wrong address, a wrong index, a data byte after index+1, a repeated START in the middle of a byte, and a STOP in the middle of a byte. Each corner separates a transaction that is acknowledged from one that is ignored, and an armed read from a read that is not armed. A seeded random mix then varies the straps, the data values and the transaction kind against a bench model of the register and the pending flag. This catches a wrong address bit, a swapped data bit and a pending flag that does not clear. A monitor counts every change of sda_oe that happens while the master holds SCL high.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
  localparam int STRAP_W = 4;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;
  localparam int CNT_W   = $clog2(DATA_W + 1);
  localparam logic [ADDR_W-STRAP_W-1:0] ADDR_TAIL = 3'b011;
  localparam logic [ADDR_W-1:0]         REG_IDX   = 7'b0000011;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_IDX, S_IDX_ACK, S_WDAT, S_WDAT_ACK, S_RDAT
  } st_t;

  // device address: inverted straps above the fixed tail
  function automatic logic [ADDR_W-1:0] dev_addr(input logic [STRAP_W-1:0] strap_n);
    return {~strap_n, ADDR_TAIL};
  endfunction

  // upper seven bits of a received byte against a wanted value
  function automatic logic byte_hits(input logic [DATA_W-1:0] b, input logic [ADDR_W-1:0] want);
    return b[DATA_W-1:1] == want;
  endfunction

  // readback value: register when armed, released bus otherwise
  function automatic logic [DATA_W-1:0] rd_byte(input logic armed, input logic [DATA_W-1:0] ctrl);
    return armed ? ctrl : {DATA_W{1'b1}};
  endfunction
endpackage

// File: rtl/i2cx_sync.sv
module i2cx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s    = scl_sh[STAGES-1];
  assign sda_s    = sda_sh[STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cx_ctrl_reg.sv
module i2cx_ctrl_reg
  import i2cx_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              arm,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= RESET_VAL;
      pend   <= 1'b0;
    end else if (wr_stb) begin
      ctrl_q <= wdata;
      pend   <= 1'b0;
    end else if (arm) begin
      pend   <= 1'b1;
    end
  end
endmodule

// File: rtl/i2cx_engine.sv
module i2cx_engine
  import i2cx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [ADDR_W-1:0] my_addr,
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic              pend,
  output logic              wr_stb,
  output logic              arm,
  output logic [DATA_W-1:0] wdata,
  output logic              sda_oe
);
  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [DATA_W-1:0] sh, tx;
  logic             rd_txn, idx_rw, ack_oe, byte_done, idx_ok;

  assign byte_done = scl_fall && (cnt == CNT_W'(DATA_W));
  assign idx_ok    = byte_hits(sh, REG_IDX);
  assign wr_stb    = byte_done && (st == S_WDAT);
  assign arm       = byte_done && (st == S_IDX) && idx_ok && !rd_txn && sh[0];
  assign wdata     = sh;
  assign sda_oe    = ack_oe | ((st == S_RDAT) & ~tx[DATA_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '1;
      rd_txn <= 1'b0;
      idx_rw <= 1'b0;
      ack_oe <= 1'b0;
    end else if (start_ev) begin
      st     <= S_DEV;
      cnt    <= '0;
      ack_oe <= 1'b0;
    end else if (stop_ev) begin
      st     <= S_IDLE;
      cnt    <= '0;
      ack_oe <= 1'b0;
    end else begin
      if (scl_rise && (st == S_DEV || st == S_IDX || st == S_WDAT)) begin
        sh  <= {sh[DATA_W-2:0], sda_s};
        cnt <= cnt + CNT_W'(1);
      end
      if (scl_fall) begin
        unique case (st)
          S_DEV: if (byte_done) begin
            cnt <= '0;
            if (byte_hits(sh, my_addr)) begin
              ack_oe <= 1'b1;
              rd_txn <= sh[0];
              st     <= S_DEV_ACK;
            end else begin
              st <= S_IDLE;
            end
          end
          S_DEV_ACK: begin
            ack_oe <= 1'b0;
            st     <= S_IDX;
          end
          S_IDX: if (byte_done) begin
            cnt <= '0;
            if (idx_ok) begin
              ack_oe <= 1'b1;
              idx_rw <= sh[0];
              st     <= S_IDX_ACK;
            end else begin
              st <= S_IDLE;
            end
          end
          S_IDX_ACK: begin
            ack_oe <= 1'b0;
            if (rd_txn) begin
              tx <= rd_byte(pend, ctrl_q);
              st <= S_RDAT;
            end else begin
              st <= idx_rw ? S_IDLE : S_WDAT;
            end
          end
          S_WDAT: if (byte_done) begin
            cnt    <= '0;
            ack_oe <= 1'b1;
            st     <= S_WDAT_ACK;
          end
          S_WDAT_ACK: begin
            ack_oe <= 1'b0;
            st     <= S_IDLE;
          end
          S_RDAT: begin
            tx <= {tx[DATA_W-2:0], 1'b1};
            if (cnt == CNT_W'(DATA_W - 1)) begin
              cnt <= '0;
              st  <= S_IDLE;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_idxreg_slave.sv
module i2c_idxreg_slave
  import i2cx_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] RESET_VAL   = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_n,
  output logic               sda_oe,
  output logic [DATA_W-1:0]  ctrl_q
);
  logic sda_s, scl_rise_w, scl_fall_w, start_w, stop_w;
  logic wr_stb_w, arm_w, pend_w;
  logic [DATA_W-1:0] wdata_w;

  i2cx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise_w), .scl_fall(scl_fall_w),
    .start_ev(start_w), .stop_ev(stop_w)
  );

  i2cx_engine u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise_w), .scl_fall(scl_fall_w),
    .start_ev(start_w), .stop_ev(stop_w),
    .my_addr(dev_addr(strap_n)), .ctrl_q(ctrl_q), .pend(pend_w),
    .wr_stb(wr_stb_w), .arm(arm_w), .wdata(wdata_w), .sda_oe(sda_oe)
  );

  i2cx_ctrl_reg #(.RESET_VAL(RESET_VAL)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb_w), .arm(arm_w),
    .wdata(wdata_w), .ctrl_q(ctrl_q), .pend(pend_w)
  );
endmodule

// File: rtl/i2cx_chk.sv
module i2cx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_fall_w,
  input logic       start_w,
  input logic       stop_w,
  input logic       wr_stb_w,
  input logic       arm_w,
  input logic       pend_w,
  input logic [7:0] ctrl_q
);
  // R7
  oe_rise_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall_w));
  // R7
  oe_fall_timed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> $past(scl_fall_w || start_w || stop_w));
  // R8
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> !sda_oe);
  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w |=> !sda_oe);
  // R4
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb_w |=> $stable(ctrl_q));
  // R4
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_w |=> !pend_w);
  // R5
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_w |=> pend_w);
endmodule

bind i2c_idxreg_slave i2cx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_fall_w(scl_fall_w),
  .start_w(start_w), .stop_w(stop_w), .wr_stb_w(wr_stb_w),
  .arm_w(arm_w), .pend_w(pend_w), .ctrl_q(ctrl_q)
);

// File: tb/test_i2c_idxreg_slave.sv
module test_i2c_idxreg_slave;
  localparam int CLK_P = 10;
  localparam int QTR   = 6;
  localparam logic [6:0] IDX = 7'b0000011;

  logic clk = 1'b0, rst_n = 1'b0, scl_drv = 1'b1, sda_drv = 1'b1;
  logic [3:0] strap_n = 4'hF;
  logic sda_oe;
  logic [7:0] ctrl_q;
  wire sda_line = sda_drv & ~sda_oe;

  int n_chk = 0, n_bad = 0, n_r7 = 0;
  bit done = 1'b0;
  logic prev_oe = 1'b0;
  logic [7:0] m_ctrl = 8'h00;
  bit m_pend = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  i2c_idxreg_slave i_i2c_idxreg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .strap_n(strap_n), .sda_oe(sda_oe), .ctrl_q(ctrl_q)
  );

  // address rule restated: straps inverted into bits 6..3, value 3 below
  function automatic logic [6:0] f_addr(input logic [3:0] s);
    return (7'(~s) << 3) | 7'd3;
  endfunction
  function automatic logic [7:0] f_read(input bit p, input logic [7:0] c);
    return p ? c : 8'hFF;
  endfunction

  // R7 monitor: sda_oe must not move while the master holds SCL high
  always @(negedge clk) begin
    if (rst_n && scl_drv && (sda_oe !== prev_oe)) n_r7++;
    prev_oe <= sda_oe;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qwait; repeat (QTR) @(negedge clk); endtask
  task automatic i2c_start;
    sda_drv = 1'b1; qwait; scl_drv = 1'b1; qwait; sda_drv = 1'b0; qwait; scl_drv = 1'b0; qwait;
  endtask
  task automatic i2c_stop;
    sda_drv = 1'b0; qwait; scl_drv = 1'b1; qwait; sda_drv = 1'b1; qwait;
  endtask
  task automatic send_bit(input logic b);
    sda_drv = b; qwait; scl_drv = 1'b1; qwait; qwait; scl_drv = 1'b0; qwait;
  endtask
  task automatic recv_bit(output logic b);
    sda_drv = 1'b1; qwait; scl_drv = 1'b1; qwait; b = sda_line; qwait; scl_drv = 1'b0; qwait;
  endtask
  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a);
    ack = ~a;
  endtask
  task automatic recv_byte(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(1'b0);
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [6:0] ix, input logic ixrw,
                        input logic [7:0] d, input bit with_data,
                        output logic ka, output logic ki, output logic kd);
    i2c_start;
    send_byte({a, 1'b0}, ka);
    send_byte({ix, ixrw}, ki);
    kd = 1'b0;
    if (with_data) send_byte(d, kd);
    i2c_stop;
  endtask
  task automatic rd_txn(input logic [6:0] a, input logic [6:0] ix,
                        output logic ka, output logic ki, output logic [7:0] d);
    i2c_start;
    send_byte({a, 1'b1}, ka);
    send_byte({ix, 1'b1}, ki);
    recv_byte(d);
    i2c_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic ka, ki, kd;
    logic [7:0] d, rd;
    logic [6:0] a;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    check("R9 ctrl_q in reset", ctrl_q, 8'h00);
    check("R9 sda_oe in reset", sda_oe, 1'b0);
    rst_n = 1'b1;
    qwait;
    check("R9 ctrl_q after reset", ctrl_q, 8'h00);

    // R6: read with nothing armed, all straps high -> address 0000011
    rd_txn(7'b0000011, IDX, ka, ki, rd);
    check("R1 address ack, straps high", ka, 1'b1);
    check("R6 index ack on read", ki, 1'b1);
    check("R6 unarmed read", rd, 8'hFF);

    // R4: single enabled path
    wr_txn(f_addr(strap_n), IDX, 1'b0, 8'h01, 1, ka, ki, kd);
    m_ctrl = 8'h01; m_pend = 0;
    check("R4 data ack", kd, 1'b1);
    check("R4 single-bit load", ctrl_q, 8'h01);

    // R10 + R5: index+1 write with stray data, then armed read
    wr_txn(f_addr(strap_n), IDX, 1'b1, 8'hC3, 1, ka, ki, kd);
    m_pend = 1;
    check("R10 data after index+1 not acked", kd, 1'b0);
    check("R10 register unchanged", ctrl_q, 8'h01);
    rd_txn(f_addr(strap_n), IDX, ka, ki, rd);
    check("R5 armed read MSB first", rd, 8'h01);

    // R4: a write clears the pending flag, read then returns FF
    wr_txn(f_addr(strap_n), IDX, 1'b0, 8'h5A, 1, ka, ki, kd);
    m_ctrl = 8'h5A; m_pend = 0;
    check("R4 load 5A", ctrl_q, 8'h5A);
    rd_txn(f_addr(strap_n), IDX, ka, ki, rd);
    check("R4 pending cleared by write", rd, 8'hFF);

    // R3: wrong index
    wr_txn(f_addr(strap_n), IDX ^ 7'h10, 1'b0, 8'h77, 1, ka, ki, kd);
    check("R3 wrong index no ack", ki, 1'b0);
    check("R3 data after wrong index no ack", kd, 1'b0);
    check("R3 register unchanged", ctrl_q, 8'h5A);

    // R2: wrong address
    wr_txn(f_addr(strap_n) ^ 7'h40, IDX, 1'b0, 8'h33, 1, ka, ki, kd);
    check("R2 wrong address no ack", ka, 1'b0);
    check("R2 later bytes ignored", {ki, kd}, 2'b00);
    check("R2 register unchanged", ctrl_q, 8'h5A);

    // R8: repeated START in the middle of the index byte
    strap_n = 4'b1010;
    i2c_start;
    send_byte({f_addr(strap_n), 1'b0}, ka);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    wr_txn(f_addr(strap_n), IDX, 1'b0, 8'hFF, 1, ka, ki, kd);
    m_ctrl = 8'hFF;
    check("R8 write after repeated start", ctrl_q, 8'hFF);
    check("R1 strap address ack", ka, 1'b1);

    // R8: STOP in the middle of the address byte
    i2c_start;
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    i2c_stop;
    check("R8 released after stop", sda_oe, 1'b0);
    wr_txn(f_addr(strap_n), IDX, 1'b0, 8'h80, 1, ka, ki, kd);
    m_ctrl = 8'h80;
    check("R8 write after aborted byte", ctrl_q, 8'h80);

    // random mix against the bench model
    for (int it = 0; it < 20; it++) begin
      int unsigned kind;
      strap_n = 4'($urandom);
      d = 8'($urandom);
      kind = $urandom % 4;
      case (kind)
        0: begin
          wr_txn(f_addr(strap_n), IDX, 1'b0, d, 1, ka, ki, kd);
          m_ctrl = d; m_pend = 0;
          check("R4 random write ack", {ka, ki, kd}, 3'b111);
          check("R4 random write value", ctrl_q, m_ctrl);
        end
        1: begin
          if ($urandom % 2 == 0) begin
            wr_txn(f_addr(strap_n), IDX, 1'b1, d, 0, ka, ki, kd);
            m_pend = 1;
          end
          rd_txn(f_addr(strap_n), IDX, ka, ki, rd);
          check("R5 random read", rd, f_read(m_pend, m_ctrl));
        end
        2: begin
          a = f_addr(strap_n) ^ 7'(1 << ($urandom % 7));
          wr_txn(a, IDX, 1'b0, d, 1, ka, ki, kd);
          check("R2 random wrong address", {ka, ki, kd}, 3'b000);
          check("R2 random register kept", ctrl_q, m_ctrl);
        end
        default: begin
          a = IDX ^ 7'(1 << ($urandom % 7));
          wr_txn(f_addr(strap_n), a, 1'b0, d, 1, ka, ki, kd);
          check("R3 random wrong index", {ka, ki, kd}, 3'b100);
          check("R3 random register kept", ctrl_q, m_ctrl);
        end
      endcase
    end

    check("R7 sda_oe changes while SCL high", n_r7, 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule